// File: doc/BRIEF.md
# Ping-Pong Eye-Scan Phase Controller

This block is the digital half of a clock and data recovery loop built on two sampling phases taken from one delay line whose taps cover two unit intervals. At any time one phase is the data phase: its sampler supplies the recovered bit. The other is the scan phase: on a start strobe it visits every tap in turn, and for each tap it counts how often its sample disagrees with the data sample over a window of 2^WIN_LOG2 bits. Every per-tap count is reported on an eye-report port so that an equalizer adaptation loop can use it as well.

Once the sweep is complete, a tap counts as open when its mismatch count does not exceed a threshold. The controller finds the longest run of open taps, treating the tap range as circular, and chooses the middle of that run. It then parks the scan phase there and runs one more confirmation window. If the two samplers still agree, the phases swap roles on a bit boundary. The old data phase becomes the scan phase for the next sweep. Because the roles alternate, the data phase can move around the delay line without limit.

The sampler bits arrive one per unit interval, and one clock cycle equals one bit.

Top module: `pingpong_eye_ctrl`

## Requirements
- R1: After reset, role_b_data is 0 (phase A carries data), tap_a and tap_b are 0, locked is 0 and eye_valid is 0.
- R2: rx_bit equals the data-phase sampler bit of the previous cycle: samp_a while role_b_data is 0, samp_b while it is 1. No bit is lost or repeated across a role swap.
- R3: A start strobe seen while idle begins a sweep. The scan-phase tap starts at 0 and advances by one every 2^WIN_LOG2 cycles through all NTAPS taps.
- R4: At the end of each sweep window, eye_valid pulses for one cycle. At the same time, eye_tap gives the swept tap and eye_cnt gives the number of bits in that window where the scan sample differed from the data sample.
- R5: A tap is open when its count is less than or equal to THRESH. A count of THRESH+1 marks the tap closed.
- R6: The chosen tap is (s + (L-1)/2) mod NTAPS, with integer division. Here L is the length of the longest circular run of open taps and s is its first tap. If runs tie, the one with the lowest s wins. When every tap is open, s=0 and L=NTAPS.
- R7: If no tap is open after a sweep, the controller returns to idle. The role, the data tap and the scan tap (left at NTAPS-1) do not change. While idle without a start, neither tap and not the role changes.
- R8: When at least one tap is open, the scan tap moves to the chosen tap one cycle after the sweep ends. A confirmation window of 2^WIN_LOG2 bits follows. If its mismatch count is at most THRESH, the roles swap at the end of the window: the data tap becomes the chosen tap and the old data tap becomes the scan tap. Otherwise nothing swaps.
- R9: locked rises with the first role swap and stays high until reset.
- R10: A start strobe during a sweep or a confirmation window is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bit-rate clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin a sweep (honoured only when idle) |
| samp_a | input | 1 | Sampler bit of phase A |
| samp_b | input | 1 | Sampler bit of phase B |
| tap_a | output | $clog2(NTAPS) | Delay-line tap for phase A |
| tap_b | output | $clog2(NTAPS) | Delay-line tap for phase B |
| role_b_data | output | 1 | 1 when phase B is the data phase |
| rx_bit | output | 1 | Recovered data bit |
| locked | output | 1 | Set after the first role swap |
| eye_valid | output | 1 | One-cycle strobe for a per-tap eye count |
| eye_tap | output | $clog2(NTAPS) | Tap that the eye count belongs to |
| eye_cnt | output | WIN_LOG2+1 | Mismatch count for that tap |

## Verification
A fault in the window counter appears at the first eye_valid pulse of a sweep, either as a wrong count or as a report at the wrong cycle. A stepping fault appears on the scan tap select in the first window. An error in the open-run search appears one cycle after the sweep ends, when the scan tap jumps to the wrong place. A fault in the swap or the recovered-data mux shows up in the very next rx_bit after the confirmation window, where a bit is dropped or repeated, or in taps that fail to exchange.

// File: rtl/epp_pkg.sv
package epp_pkg;
  typedef enum logic [1:0] {
    ST_IDLE   = 2'd0,
    ST_SWEEP  = 2'd1,
    ST_PICK   = 2'd2,
    ST_VERIFY = 2'd3
  } ctl_state_e;
endpackage

// File: rtl/epp_win_counter.sv
// Counts mismatches over a window of 2^WIN_LOG2 bits.
module epp_win_counter #(
  parameter int WIN_LOG2 = 4
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                clear,
  input  logic                enable,
  input  logic                mism,
  output logic                win_done,
  output logic [WIN_LOG2:0]   win_cnt
);
  localparam int CNT_W = WIN_LOG2 + 1;

  logic [WIN_LOG2-1:0] bit_idx;
  logic [CNT_W-1:0]    acc;

  assign win_done = enable && (&bit_idx);
  assign win_cnt  = acc + CNT_W'(mism);

  always_ff @(posedge clk) begin
    if (!rst_n || clear) begin
      bit_idx <= '0;
      acc     <= '0;
    end else if (enable) begin
      if (win_done) begin
        bit_idx <= '0;
        acc     <= '0;
      end else begin
        bit_idx <= bit_idx + WIN_LOG2'(1);
        acc     <= win_cnt;
      end
    end
  end
endmodule

// File: rtl/epp_run_finder.sv
// Midpoint of the longest circular run of open taps.
module epp_run_finder #(
  parameter int NTAPS = 16,
  parameter int TAP_W = $clog2(NTAPS)
) (
  input  logic [NTAPS-1:0] open_mask,
  output logic             found,
  output logic [TAP_W-1:0] best_tap
);
  function automatic logic [TAP_W:0] mid_of_longest(input logic [NTAPS-1:0] m);
    int best_len;
    int best_start;
    int len;
    bit run;
    best_len   = 0;
    best_start = 0;
    if (&m) begin
      best_len = NTAPS;
    end else begin
      for (int s = 0; s < NTAPS; s++) begin
        if (m[s] && !m[(s + NTAPS - 1) % NTAPS]) begin
          len = 0;
          run = 1'b1;
          for (int k = 0; k < NTAPS; k++) begin
            if (run && m[(s + k) % NTAPS]) len++;
            else run = 1'b0;
          end
          if (len > best_len) begin
            best_len   = len;
            best_start = s;
          end
        end
      end
    end
    if (best_len == 0) return '0;
    return {1'b1, TAP_W'((best_start + (best_len - 1) / 2) % NTAPS)};
  endfunction

  logic [TAP_W:0] res;
  assign res      = mid_of_longest(open_mask);
  assign found    = res[TAP_W];
  assign best_tap = res[TAP_W-1:0];
endmodule

// File: rtl/pingpong_eye_ctrl.sv
module pingpong_eye_ctrl #(
  parameter int NTAPS    = 16,
  parameter int WIN_LOG2 = 4,
  parameter int THRESH   = 1
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       start,
  input  logic                       samp_a,
  input  logic                       samp_b,
  output logic [$clog2(NTAPS)-1:0]   tap_a,
  output logic [$clog2(NTAPS)-1:0]   tap_b,
  output logic                       role_b_data,
  output logic                       rx_bit,
  output logic                       locked,
  output logic                       eye_valid,
  output logic [$clog2(NTAPS)-1:0]   eye_tap,
  output logic [WIN_LOG2:0]          eye_cnt
);
  import epp_pkg::*;

  localparam int TAP_W = $clog2(NTAPS);
  localparam int CNT_W = WIN_LOG2 + 1;

  ctl_state_e        state;
  logic [TAP_W-1:0]  data_tap, scan_tap;
  logic [NTAPS-1:0]  open_mask;

  // Named internal events, observed by the checker.
  logic              samp_data, samp_scan, mism;
  logic              win_done, win_open, sweep_last, swap_ev, ctl_idle;
  logic [CNT_W-1:0]  win_cnt;
  logic              found;
  logic [TAP_W-1:0]  best_tap;

  assign samp_data  = role_b_data ? samp_b : samp_a;
  assign samp_scan  = role_b_data ? samp_a : samp_b;
  assign mism       = samp_data ^ samp_scan;
  assign win_open   = (win_cnt <= CNT_W'(THRESH));
  assign sweep_last = (scan_tap == TAP_W'(NTAPS - 1));
  assign swap_ev    = (state == ST_VERIFY) && win_done && win_open;
  assign ctl_idle   = (state == ST_IDLE);

  assign tap_a = role_b_data ? scan_tap : data_tap;
  assign tap_b = role_b_data ? data_tap : scan_tap;

  epp_win_counter #(.WIN_LOG2(WIN_LOG2)) u_win (
    .clk      (clk),
    .rst_n    (rst_n),
    .clear    (ctl_idle || (state == ST_PICK)),
    .enable   ((state == ST_SWEEP) || (state == ST_VERIFY)),
    .mism     (mism),
    .win_done (win_done),
    .win_cnt  (win_cnt)
  );

  epp_run_finder #(.NTAPS(NTAPS), .TAP_W(TAP_W)) u_find (
    .open_mask (open_mask),
    .found     (found),
    .best_tap  (best_tap)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) rx_bit <= 1'b0;
    else        rx_bit <= samp_data;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state       <= ST_IDLE;
      data_tap    <= '0;
      scan_tap    <= '0;
      role_b_data <= 1'b0;
      locked      <= 1'b0;
      open_mask   <= '0;
      eye_valid   <= 1'b0;
      eye_tap     <= '0;
      eye_cnt     <= '0;
    end else begin
      eye_valid <= 1'b0;
      case (state)
        ST_IDLE: begin
          if (start) begin
            scan_tap  <= '0;
            open_mask <= '0;
            state     <= ST_SWEEP;
          end
        end
        ST_SWEEP: begin
          if (win_done) begin
            eye_valid           <= 1'b1;
            eye_tap             <= scan_tap;
            eye_cnt             <= win_cnt;
            open_mask[scan_tap] <= win_open;
            if (sweep_last) state <= ST_PICK;
            else            scan_tap <= scan_tap + TAP_W'(1);
          end
        end
        ST_PICK: begin
          if (found) begin
            scan_tap <= best_tap;
            state    <= ST_VERIFY;
          end else begin
            state <= ST_IDLE;
          end
        end
        ST_VERIFY: begin
          if (win_done) begin
            state <= ST_IDLE;
            if (swap_ev) begin
              data_tap    <= scan_tap;
              scan_tap    <= data_tap;
              role_b_data <= ~role_b_data;
              locked      <= 1'b1;
            end
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/pingpong_eye_ctrl_checks.sv
module pingpong_eye_ctrl_checks #(
  parameter int NTAPS = 16,
  parameter int TAP_W = $clog2(NTAPS)
) (
  input logic             clk,
  input logic             rst_n,
  input logic             start,
  input logic             samp_a,
  input logic             samp_b,
  input logic [TAP_W-1:0] tap_a,
  input logic [TAP_W-1:0] tap_b,
  input logic             role_b_data,
  input logic             rx_bit,
  input logic             locked,
  input logic             eye_valid,
  input logic             ctl_idle,
  input logic [TAP_W-1:0] data_tap,
  input logic [TAP_W-1:0] scan_tap
);
  logic armed;
  always_ff @(posedge clk) begin
    if (!rst_n) armed <= 1'b0;
    else        armed <= 1'b1;
  end

  p_rx_follow_r2: assert property (@(posedge clk) disable iff (!rst_n)
    armed |-> rx_bit == ($past(role_b_data) ? $past(samp_b) : $past(samp_a)));

  p_eye_pulse_r4: assert property (@(posedge clk) disable iff (!rst_n)
    eye_valid |=> !eye_valid);

  p_idle_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (ctl_idle && !start) |=> ($stable(tap_a) && $stable(tap_b) && $stable(role_b_data)));

  p_swap_taps_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (armed && role_b_data != $past(role_b_data)) |->
      (data_tap == $past(scan_tap) && scan_tap == $past(data_tap)));

  p_lock_sticky_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (armed && $past(locked)) |-> locked);

  p_lock_swap_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (armed && $rose(locked)) |-> role_b_data != $past(role_b_data));
endmodule

bind pingpong_eye_ctrl pingpong_eye_ctrl_checks #(.NTAPS(NTAPS)) u_checks (
  .clk         (clk),
  .rst_n       (rst_n),
  .start       (start),
  .samp_a      (samp_a),
  .samp_b      (samp_b),
  .tap_a       (tap_a),
  .tap_b       (tap_b),
  .role_b_data (role_b_data),
  .rx_bit      (rx_bit),
  .locked      (locked),
  .eye_valid   (eye_valid),
  .ctl_idle    (ctl_idle),
  .data_tap    (data_tap),
  .scan_tap    (scan_tap)
);

// File: tb/test_pingpong_eye_ctrl.sv
module test_pingpong_eye_ctrl;
  localparam int N   = 16;
  localparam int WL  = 4;
  localparam int WIN = 1 << WL;
  localparam int TH  = 1;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start = 1'b0, samp_a = 1'b0, samp_b = 1'b0;
  logic [3:0] tap_a, tap_b, eye_tap;
  logic role_b_data, rx_bit, locked, eye_valid;
  logic [WL:0] eye_cnt;

  int checks = 0, fails = 0;
  int q_tap[$], q_cnt[$];
  bit have_last = 0;
  logic last_d = 1'b0;
  int err[N];

  always #5 clk = ~clk;

  pingpong_eye_ctrl #(.NTAPS(N), .WIN_LOG2(WL), .THRESH(TH)) i_pingpong_eye_ctrl (
    .clk(clk), .rst_n(rst_n), .start(start), .samp_a(samp_a), .samp_b(samp_b),
    .tap_a(tap_a), .tap_b(tap_b), .role_b_data(role_b_data), .rx_bit(rx_bit),
    .locked(locked), .eye_valid(eye_valid), .eye_tap(eye_tap), .eye_cnt(eye_cnt));

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  endtask

  // Monitor: per-tap eye reports against the scoreboard (R4, R5 counts).
  always @(negedge clk) begin
    if (rst_n && eye_valid) begin
      if (q_tap.size() == 0) chk("R4 unexpected eye report", 1, 0);
      else begin
        chk("R4 eye_tap", int'(eye_tap), q_tap.pop_front());
        chk("R4 eye_cnt", int'(eye_cnt), q_cnt.pop_front());
      end
    end
  end

  // Driver: one bit per cycle, rx_bit checked against the previous bit (R2).
  task automatic drive_bit(input bit inj, input bit st);
    logic d;
    @(negedge clk);
    if (have_last) chk("R2 rx_bit", int'(rx_bit), int'(last_d));
    d = 1'($urandom);
    start = st;
    if (!role_b_data) begin samp_a = d; samp_b = d ^ inj; end
    else              begin samp_b = d; samp_a = d ^ inj; end
    last_d = d;
    have_last = 1;
  endtask

  function automatic int scan_tap_now();
    return role_b_data ? int'(tap_a) : int'(tap_b);
  endfunction

  // One full sweep; mid_start injects a start strobe mid-sweep (R10).
  task automatic run_sweep(input bit has_verify, input int exp_best, input int verr,
                           input bit mid_start);
    for (int t = 0; t < N; t++) begin
      q_tap.push_back(t);
      q_cnt.push_back(err[t]);
    end
    drive_bit(0, 1);
    for (int t = 0; t < N; t++)
      for (int b = 0; b < WIN; b++) begin
        drive_bit(b < err[t], mid_start && t == 5 && b == 3);
        if (b == 0) chk("R3 scan tap step", scan_tap_now(), t);
      end
    drive_bit(0, 0);  // pick cycle
    if (has_verify)
      for (int b = 0; b < WIN; b++) begin
        drive_bit(b < verr, 0);
        if (b == 0) chk("R6 chosen tap", scan_tap_now(), exp_best);
      end
    for (int i = 0; i < 4; i++) drive_bit(0, 0);
    chk("R4 all eye reports seen", q_tap.size(), 0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    fails++; checks++;
    $display("FAIL watchdog: actual expired expected done");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1: reset state
    chk("R1 role", int'(role_b_data), 0);
    chk("R1 tap_a", int'(tap_a), 0);
    chk("R1 tap_b", int'(tap_b), 0);
    chk("R1 locked", int'(locked), 0);
    chk("R1 eye_valid", int'(eye_valid), 0);
    for (int i = 0; i < 3; i++) drive_bit(0, 0);

    // S1: closed taps 3..6, open run 7..2 wraps, len 12 -> 7+5 = 12; swap (R8, R9)
    foreach (err[t]) err[t] = (t >= 3 && t <= 6) ? 5 : 0;
    run_sweep(1, 12, 0, 0);
    chk("R8 role after swap", int'(role_b_data), 1);
    chk("R8 tap_b data", int'(tap_b), 12);
    chk("R8 tap_a scan", int'(tap_a), 0);
    chk("R9 locked", int'(locked), 1);

    // S2: threshold edges (R5), wrap run 14..2 len 5 beats 5..8 len 4 -> 0; verify fails
    foreach (err[t]) err[t] = 0;
    err[15] = TH; err[3] = TH + 1; err[4] = 9;
    for (int t = 9; t <= 13; t++) err[t] = WIN;
    run_sweep(1, 0, 5, 1);
    chk("R8 no swap role", int'(role_b_data), 1);
    chk("R8 no swap tap_b", int'(tap_b), 12);
    chk("R9 lock holds", int'(locked), 1);

    // S3: every tap closed -> nothing changes (R7)
    foreach (err[t]) err[t] = TH + 2;
    run_sweep(0, 0, 0, 0);
    chk("R7 role kept", int'(role_b_data), 1);
    chk("R7 tap_b kept", int'(tap_b), 12);
    chk("R7 scan tap at last", int'(tap_a), N - 1);

    // S4: all open -> (N-1)/2 = 7; verify count at threshold still swaps (R5, R6, R8)
    foreach (err[t]) err[t] = 0;
    run_sweep(1, 7, TH, 0);
    chk("R8 role back to A", int'(role_b_data), 0);
    chk("R8 tap_a data", int'(tap_a), 7);
    chk("R8 tap_b scan", int'(tap_b), 12);

    // S5: two equal runs 2..4 and 9..11 -> lower start wins, tap 3 (R6)
    foreach (err[t]) err[t] = ((t >= 2 && t <= 4) || (t >= 9 && t <= 11)) ? 0 : 4;
    run_sweep(1, 3, 0, 0);
    chk("R6 tie role", int'(role_b_data), 1);
    chk("R6 tie tap_b", int'(tap_b), 3);
    chk("R6 tie tap_a", int'(tap_a), 7);

    finish_run();
  end
endmodule